// File: doc/BRIEF.md
# Two-Byte I2C Configuration Receiver

This block is a receive-only I2C target that loads a 16-bit configuration word. After a START, it collects an address byte. That byte holds a six-bit hardwired prefix, one address bit chosen by a pin, and the direction bit. If the address is its own and the direction is write, it acknowledges. It then takes two data bytes and acknowledges each of them.

The first data byte becomes the upper half of the word and the second becomes the lower half. Each half is committed at the end of its acknowledge clock. A one-cycle strobe marks the commit of the lower half. The bus lines are sampled with the system clock through a synchroniser, so SCL must be much slower than `clk`. The target pulls SDA low through an open-drain enable.

States: `ST_IDLE` (waits for START), `ST_ADDR` (shifts the address byte), `ST_ADDR_ACK`, `ST_MSB` (upper data byte), `ST_MSB_ACK`, `ST_LSB` (lower data byte) and `ST_LSB_ACK`.

Transitions:
- A START from any state goes to `ST_ADDR`. A STOP from any state goes to `ST_IDLE`.
- At the SCL fall that ends the eighth bit, each receive state moves to its acknowledge state. In `ST_ADDR` this happens only if the address matches; otherwise the block goes to `ST_IDLE`.
- At the SCL fall that ends the ninth clock, the acknowledge states advance in turn: `ST_ADDR_ACK` to `ST_MSB`, `ST_MSB_ACK` to `ST_LSB`, and `ST_LSB_ACK` to `ST_IDLE`.

Top module: `i2c_cfg_slave`

## Requirements
- R1: After reset, `cfg_o` is 0x0000, `sda_oe_o` is 0 and `cfg_upd_o` is 0.
- R2: A START is SDA falling while SCL is high, and it begins address reception. A STOP is SDA rising while SCL is high, and it returns the block to idle with SDA released.
- R3: The address byte is sent MSB first and equals {001011, NOT `adr_sel_i`, R/W}. With `adr_sel_i`=0 the 7-bit address is 0x17; with `adr_sel_i`=1 it is 0x16. When the address matches and R/W=0, `sda_oe_o` is 1 throughout the high phase of the ninth clock.
- R4: A mismatching address, or R/W=1, gets no acknowledge. The following bytes of that transfer are not acknowledged and leave `cfg_o` unchanged.
- R5: The first data byte is acknowledged and is written to `cfg_o[15:8]` at the SCL fall that ends its acknowledge clock.
- R6: The second data byte is acknowledged and is written to `cfg_o[7:0]` at the SCL fall that ends its acknowledge clock. `cfg_upd_o` pulses for exactly one cycle at that commit, and `cfg_o[7:0]` never changes without it.
- R7: Any byte after the second data byte, before a STOP or START, is not acknowledged and does not alter `cfg_o`.
- R8: A repeated START at any point discards any partially received byte and restarts address reception.
- R9: `sda_oe_o` changes only while SCL is low. It is released at the SCL fall that ends each acknowledge clock.
- R10: A STOP in the middle of the second data byte leaves `cfg_o[7:0]` unchanged and produces no `cfg_upd_o` pulse. An upper half already committed stays in place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level (wired-AND bus value) |
| adr_sel_i | input | 1 | Address select pin; its inverse is the address LSB |
| sda_oe_o | output | 1 | 1 pulls SDA low (open-drain enable) |
| cfg_o | output | 16 | Configuration word; the first byte lands in bits 15:8 |
| cfg_upd_o | output | 1 | One-cycle strobe when the lower byte is committed |

## Verification
The bench builds the block with `SYNC_STAGES`=3, one stage deeper than the default. This lengthens the path from a bus edge to a state change and shows that the acknowledge and commit timing depend only on the synchronised SCL edges. The prefix stays at its default, and the bench drives both settings of `adr_sel_i`. This covers both own addresses as well as an address that is correct for the other pin setting.

// File: rtl/i2c_cfg_pkg.sv
package i2c_cfg_pkg;
    localparam int BYTE_W = 8;
    localparam int WORD_W = 2 * BYTE_W;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_MSB,
        ST_MSB_ACK,
        ST_LSB,
        ST_LSB_ACK
    } rx_state_t;
endpackage

// File: rtl/i2c_line_sync.sv
// Multi-stage synchroniser for one bus line; also exposes the previous
// synchronised value so edges and START/STOP can be decoded.
module i2c_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic level_o,
    output logic prev_o
);
    logic [STAGES:0] pipe;
    assign pipe[0] = line_i;

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pipe[g+1] <= 1'b1;
            else        pipe[g+1] <= pipe[g];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_o <= 1'b1;
        else        prev_o <= pipe[STAGES];
    end

    assign level_o = pipe[STAGES];
endmodule

// File: rtl/i2c_byte_shift.sv
// MSB-first byte collector with a bit counter.
module i2c_byte_shift #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr_i,
    input  logic         shift_i,
    input  logic         bit_i,
    output logic [W-1:0] data_o,
    output logic         full_o
);
    localparam int CW = $clog2(W + 1);
    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt    <= '0;
            data_o <= '0;
        end else if (clr_i) begin
            cnt    <= '0;
        end else if (shift_i) begin
            cnt    <= cnt + 1'b1;
            data_o <= {data_o[W-2:0], bit_i};
        end
    end

    assign full_o = (cnt == CW'(W));
endmodule

// File: rtl/i2c_cfg_slave.sv
module i2c_cfg_slave
    import i2c_cfg_pkg::*;
#(
    parameter int         SYNC_STAGES = 2,
    parameter logic [5:0] ADDR_PREFIX = 6'b001011
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        scl_i,
    input  logic        sda_i,
    input  logic        adr_sel_i,
    output logic        sda_oe_o,
    output logic [15:0] cfg_o,
    output logic        cfg_upd_o
);
    rx_state_t state, nxt;

    logic scl_lvl, scl_prev, sda_lvl, sda_prev;
    logic scl_rise, scl_fall, start_w, stop_w;
    logic rx_state, ack_state, shift_en, byte_end, ack_end, clr_sh;
    logic addr_ok, sh_full;
    logic [BYTE_W-1:0] sh_data;
    logic [6:0] own_addr;

    i2c_line_sync #(.STAGES(SYNC_STAGES)) u_scl (
        .clk(clk), .rst_n(rst_n), .line_i(scl_i),
        .level_o(scl_lvl), .prev_o(scl_prev)
    );
    i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sda (
        .clk(clk), .rst_n(rst_n), .line_i(sda_i),
        .level_o(sda_lvl), .prev_o(sda_prev)
    );

    assign scl_rise = scl_lvl & ~scl_prev;
    assign scl_fall = ~scl_lvl & scl_prev;
    assign start_w  = scl_lvl & scl_prev & sda_prev & ~sda_lvl;
    assign stop_w   = scl_lvl & scl_prev & ~sda_prev & sda_lvl;

    assign rx_state  = (state == ST_ADDR) || (state == ST_MSB) || (state == ST_LSB);
    assign ack_state = (state == ST_ADDR_ACK) || (state == ST_MSB_ACK) || (state == ST_LSB_ACK);
    assign shift_en  = rx_state & scl_rise & ~sh_full;
    assign byte_end  = rx_state & scl_fall & sh_full;
    assign ack_end   = ack_state & scl_fall;
    assign clr_sh    = start_w | stop_w | ack_end | (state == ST_IDLE);

    assign own_addr = {ADDR_PREFIX, ~adr_sel_i};
    assign addr_ok  = (sh_data == {own_addr, 1'b0});

    i2c_byte_shift #(.W(BYTE_W)) u_shift (
        .clk(clk), .rst_n(rst_n), .clr_i(clr_sh), .shift_i(shift_en),
        .bit_i(sda_lvl), .data_o(sh_data), .full_o(sh_full)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // Next-state logic
    always_comb begin
        nxt = state;
        if (start_w) begin
            nxt = ST_ADDR;
        end else if (stop_w) begin
            nxt = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE:     nxt = ST_IDLE;
                ST_ADDR:     if (byte_end) nxt = addr_ok ? ST_ADDR_ACK : ST_IDLE;
                ST_ADDR_ACK: if (scl_fall) nxt = ST_MSB;
                ST_MSB:      if (byte_end) nxt = ST_MSB_ACK;
                ST_MSB_ACK:  if (scl_fall) nxt = ST_LSB;
                ST_LSB:      if (byte_end) nxt = ST_LSB_ACK;
                ST_LSB_ACK:  if (scl_fall) nxt = ST_IDLE;
                default:     nxt = ST_IDLE;
            endcase
        end
    end

    // Outputs: acknowledge drive, register halves, update strobe
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sda_oe_o  <= 1'b0;
            cfg_o     <= '0;
            cfg_upd_o <= 1'b0;
        end else begin
            cfg_upd_o <= 1'b0;
            if (start_w || stop_w) begin
                sda_oe_o <= 1'b0;
            end else if (byte_end && (state != ST_ADDR || addr_ok)) begin
                sda_oe_o <= 1'b1;
            end else if (ack_end) begin
                sda_oe_o <= 1'b0;
                if (state == ST_MSB_ACK) begin
                    cfg_o[WORD_W-1:BYTE_W] <= sh_data;
                end else if (state == ST_LSB_ACK) begin
                    cfg_o[BYTE_W-1:0] <= sh_data;
                    cfg_upd_o         <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/i2c_cfg_slave_chk.sv
module i2c_cfg_slave_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        scl_lvl,
    input logic        scl_fall,
    input logic        stop_w,
    input logic        sda_oe,
    input logic [15:0] cfg,
    input logic        upd
);
    p_oe_scl_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> !scl_lvl)
        else $error("sda_oe changed while SCL high");

    p_stop_release_r2: assert property (@(posedge clk) disable iff (!rst_n)
        stop_w |=> !sda_oe)
        else $error("SDA held after STOP");

    p_upd_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        upd |=> !upd)
        else $error("update strobe longer than one cycle");

    p_lsb_with_upd_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cfg[7:0]) |-> upd)
        else $error("low byte changed without strobe");

    p_msb_at_fall_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cfg[15:8]) |-> $past(scl_fall))
        else $error("high byte changed away from an SCL fall");
endmodule

bind i2c_cfg_slave i2c_cfg_slave_chk u_chk (
    .clk(clk), .rst_n(rst_n), .scl_lvl(scl_lvl), .scl_fall(scl_fall),
    .stop_w(stop_w), .sda_oe(sda_oe_o), .cfg(cfg_o), .upd(cfg_upd_o)
);

// File: tb/sim_i2c_cfg_slave.sv
`timescale 1ns/1ps
module sim_i2c_cfg_slave;
    localparam int H = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl = 1'b1;
    logic sda_m = 1'b1;
    logic adr_sel = 1'b0;
    logic sda_oe;
    logic [15:0] cfg;
    logic upd;
    logic sda_bus;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    bit mon_on = 1'b0;
    bit flux = 1'b0;
    logic [15:0] exp_cfg = 16'h0000;
    int exp_upd = 0;
    int upd_cnt = 0;
    logic prev_oe = 1'b0;

    always #5 clk = ~clk;

    assign sda_bus = sda_m & ~sda_oe;

    i2c_cfg_slave #(.SYNC_STAGES(3)) u0 (
        .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_bus),
        .adr_sel_i(adr_sel), .sda_oe_o(sda_oe), .cfg_o(cfg), .cfg_upd_o(upd)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Reference comparison on every clock
    always @(negedge clk) begin
        if (mon_on) begin
            if (upd === 1'b1) upd_cnt++;
            if (!flux) check(cfg === exp_cfg, "R5/R6 cfg word", {16'h0, cfg}, {16'h0, exp_cfg});
            if (sda_oe !== prev_oe) check(scl === 1'b0, "R9 oe change with SCL low", {31'h0, scl}, 32'h0);
            prev_oe = sda_oe;
        end
    end

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
    endtask

    task automatic do_start();
        sda_m <= 1'b0; tick(H);
        scl   <= 1'b0; tick(4);
    endtask

    task automatic do_rstart();
        sda_m <= 1'b1; tick(H);
        scl   <= 1'b1; tick(H);
        sda_m <= 1'b0; tick(H);
        scl   <= 1'b0; tick(4);
    endtask

    task automatic do_stop();
        sda_m <= 1'b0; tick(H);
        scl   <= 1'b1; tick(H);
        sda_m <= 1'b1; tick(H);
    endtask

    task automatic send_bit(input logic b);
        sda_m <= b;    tick(H);
        scl   <= 1'b1; tick(H);
        scl   <= 1'b0; tick(4);
    endtask

    // latch: 0 none, 1 upper byte, 2 lower byte
    task automatic ack_bit(input bit exp_ack, input string tag, input int latch, input logic [7:0] val);
        sda_m <= 1'b1; tick(H);
        scl   <= 1'b1; tick(H/2);
        @(negedge clk);
        check(sda_oe === exp_ack, tag, {31'h0, sda_oe}, {31'h0, exp_ack});
        tick(H/2);
        scl  <= 1'b0;
        flux = 1'b1;
        tick(10);
        if (latch == 1) exp_cfg[15:8] = val;
        if (latch == 2) begin exp_cfg[7:0] = val; exp_upd++; end
        flux = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] b, input bit exp_ack, input string tag, input int latch);
        for (int i = 7; i >= 0; i--) send_bit(b[i]);
        ack_bit(exp_ack, tag, latch, b);
    endtask

    task automatic end_check(input string tag);
        tick(4);
        @(negedge clk);
        check(cfg === exp_cfg, tag, {16'h0, cfg}, {16'h0, exp_cfg});
        check(upd_cnt == exp_upd, tag, upd_cnt, exp_upd);
        check(sda_oe === 1'b0, "R2 SDA released after STOP", {31'h0, sda_oe}, 32'h0);
    endtask

    initial begin
        tick(5);
        @(negedge clk);
        check(cfg === 16'h0 && sda_oe === 1'b0 && upd === 1'b0, "R1 reset state",
              {15'h0, upd, cfg}, 32'h0);
        rst_n <= 1'b1;
        tick(4);
        mon_on = 1'b1;

        // Address 0x17 with pin low, write FF FC
        adr_sel <= 1'b0;
        do_start();
        send_byte({7'h17, 1'b0}, 1'b1, "R3 ack addr pin low", 0);
        send_byte(8'hFF, 1'b1, "R5 ack first byte", 1);
        send_byte(8'hFC, 1'b1, "R6 ack second byte", 2);
        do_stop();
        end_check("R6 word FFFC");

        // Address 0x16 with pin high, write 12 34
        adr_sel <= 1'b1;
        tick(H);
        do_start();
        send_byte({7'h16, 1'b0}, 1'b1, "R3 ack addr pin high", 0);
        send_byte(8'h12, 1'b1, "R5 ack byte 12", 1);
        send_byte(8'h34, 1'b1, "R6 ack byte 34", 2);
        do_stop();
        end_check("R5 word 1234");

        // Wrong address for pin high
        do_start();
        send_byte({7'h17, 1'b0}, 1'b0, "R4 no ack wrong addr", 0);
        send_byte(8'hAA, 1'b0, "R4 no ack data after miss", 0);
        send_byte(8'h55, 1'b0, "R4 no ack data after miss", 0);
        do_stop();
        end_check("R4 word unchanged");

        // Read direction
        do_start();
        send_byte({7'h16, 1'b1}, 1'b0, "R4 no ack read bit", 0);
        send_byte(8'h99, 1'b0, "R4 no ack data after read", 0);
        do_stop();
        end_check("R4 read leaves word");

        // Third data byte ignored
        do_start();
        send_byte({7'h16, 1'b0}, 1'b1, "R3 ack addr", 0);
        send_byte(8'hA5, 1'b1, "R5 ack byte A5", 1);
        send_byte(8'h5A, 1'b1, "R6 ack byte 5A", 2);
        send_byte(8'h77, 1'b0, "R7 no ack third byte", 0);
        do_stop();
        end_check("R7 word A55A");

        // Repeated START inside upper byte
        do_start();
        send_byte({7'h16, 1'b0}, 1'b1, "R3 ack addr", 0);
        send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
        do_rstart();
        send_byte({7'h16, 1'b0}, 1'b1, "R8 ack addr after rstart", 0);
        send_byte(8'h3C, 1'b1, "R8 ack byte 3C", 1);
        send_byte(8'hC3, 1'b1, "R8 ack byte C3", 2);
        do_stop();
        end_check("R8 word 3CC3");

        // Repeated START inside address byte, pin low
        adr_sel <= 1'b0;
        tick(H);
        do_start();
        send_bit(1'b0); send_bit(1'b1);
        do_rstart();
        send_byte({7'h17, 1'b0}, 1'b1, "R8 ack addr after partial", 0);
        send_byte(8'h01, 1'b1, "R8 ack byte 01", 1);
        send_byte(8'h80, 1'b1, "R8 ack byte 80", 2);
        do_stop();
        end_check("R8 word 0180");

        // STOP inside lower byte
        do_start();
        send_byte({7'h17, 1'b0}, 1'b1, "R3 ack addr", 0);
        send_byte(8'hE7, 1'b1, "R10 ack byte E7", 1);
        send_bit(1'b1); send_bit(1'b1); send_bit(1'b0); send_bit(1'b0);
        do_stop();
        end_check("R10 word E780");

        tick(H);
        mon_on = 1'b0;
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule